// File: doc/BRIEF.md
# Call and Interrupt Linkage Sequencer

This block sequences subroutine calls and interrupt entry for a small accumulator machine that has no hardware stack. For a call, it writes the return address into the memory word named by the effective address. Execution then resumes one word further on. The subroutine therefore keeps its own return slot in the word just before its first instruction, and it returns with an indirect jump through that slot.

An interrupt is entered the same way, as a forced call to word 0. The return address goes to word 0, fetching continues at word 1, and further interrupts are switched off.

The block also resolves priority among the requesting devices. It takes the lowest request index first, which models a fixed poll chain, and a poll that finds nobody is a normal outcome. Interrupts are switched back on by an enable command that acts with a delay of one instruction. A handler can therefore issue the enable just before its return jump, and the return completes before any new interrupt can be accepted.

The surrounding core presents one instruction boundary per `step_i` pulse. With each pulse it supplies the address of the instruction about to run (`pc_i`), its resolved effective address (`ea_i`) and the linkage opcode (`op_i`). The block answers in the same cycle with an optional memory write and the next PC.

Top module: `link_seq`

## Requirements
- R1: On a step with op 1 (call) and no interrupt taken, the block asserts `mem_we_o` for that cycle, with `mem_addr_o` = `ea_i` and `mem_wdata_o` = `pc_i`+1 (modulo 2^AW).
- R2: On a step with op 1 (call) and no interrupt taken, `next_pc_o` = `ea_i`+1 (modulo 2^AW).
- R3: An interrupt is accepted on a step where interrupts are enabled and at least one request bit is set. `int_taken_o` is high in that cycle. The opcode is not executed. Instead, `pc_i` is written to address 0 and `next_pc_o` = 1. `int_on_o` reads 0 from the next cycle on.
- R4: On a step with op 3 (jump), `next_pc_o` = `ea_i` and no write occurs. On a step with op 0 (sequential), `next_pc_o` = `pc_i`+1 and no write occurs.
- R5: A step with op 2 (enable) does not raise `int_on_o` after its own edge. `int_on_o` rises only after the next step completes, so that next step is never interrupted.
- R6: `grant_o` is one-hot on the lowest-indexed set bit of `req_i`, and `grant_valid_o` is high whenever any request bit is set.
- R7: With no request bit set, `grant_o` is 0 and `grant_valid_o` is 0. No interrupt is taken even when interrupts are enabled, and the step executes normally.
- R8: After reset, `int_on_o` is 0, any pending enable is cleared, and with no step the block drives no write and `next_pc_o` = `pc_i`.
- R9: While interrupts are disabled, requests cause no interrupt, and the step's opcode executes normally.
- R10: Without `step_i`, the block performs no write and `next_pc_o` = `pc_i`. A pending enable is held until the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction boundary: the opcode below executes this cycle |
| op_i | input | 2 | 0 sequential, 1 call, 2 enable interrupts, 3 jump |
| pc_i | input | AW | Address of the instruction about to run |
| ea_i | input | AW | Resolved effective address or jump target |
| req_i | input | NDEV | Device request vector, bit 0 highest priority |
| mem_we_o | output | 1 | Memory write strobe for the return address |
| mem_addr_o | output | AW | Address of the return-slot write |
| mem_wdata_o | output | AW | Return address written |
| next_pc_o | output | AW | PC of the next instruction fetch |
| int_taken_o | output | 1 | Interrupt accepted on this step |
| int_on_o | output | 1 | Interrupts currently enabled |
| grant_o | output | NDEV | One-hot grant to the highest-priority requester |
| grant_valid_o | output | 1 | At least one device is requesting |

## Verification
The in-RTL assertions check several properties on every clock:
- the grant is one-hot, lies inside the request vector, and has no lower-index requester;
- every return-slot write is paired with a next PC one word past the slot;
- an interrupt is taken only when interrupts are enabled and a grant exists;
- interrupts are off after an entry, and the enable only rises out of a pending state.

Only the directed scenarios can show the rest:
- the actual return addresses and targets against independently computed values;
- the full enable sequence, where the return jump runs uninterrupted and the next step is taken;
- the empty poll, idle cycles holding a pending enable, and address wrap at the top of memory.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_CALL = 2'd1,
    OP_ION  = 2'd2,
    OP_JUMP = 2'd3
  } link_op_e;
endpackage

// File: rtl/link_prio.sv
module link_prio #(
  parameter int NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] req_i,
  output logic [NDEV-1:0] grant_o,
  output logic            grant_valid_o
);
  // lowest set bit isolated by two's complement
  logic [NDEV-1:0] neg_req;
  assign neg_req       = (~req_i) + {{(NDEV-1){1'b0}}, 1'b1};
  assign grant_o       = req_i & neg_req;
  assign grant_valid_o = (grant_o != '0);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R6
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0); // R6
  AST_EMPTY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !grant_valid_o); // R7

  for (genvar gi = 1; gi < NDEV; gi++) begin : g_order
    AST_NO_LOWER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[gi] |-> (req_i[gi-1:0] == '0)); // R6
  end
endmodule

// File: rtl/link_ie_ctrl.sv
module link_ie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic ion_exec_i,
  input  logic int_taken_i,
  output logic int_on_o,
  output logic ion_pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_on_o   <= 1'b0;
      ion_pend_o <= 1'b0;
    end else if (int_taken_i) begin
      int_on_o   <= 1'b0;
      ion_pend_o <= 1'b0;
    end else if (step_i) begin
      if (ion_pend_o) int_on_o <= 1'b1;
      ion_pend_o <= ion_exec_i;
    end
  end

  AST_OFF_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    int_taken_i |=> !int_on_o); // R3
  AST_ENABLE_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    (ion_exec_i && !ion_pend_o && !int_on_o) |=> !int_on_o); // R5
  AST_RISE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_on_o) |-> $past(ion_pend_o)); // R5
  AST_PEND_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !int_taken_i) |=> $stable(ion_pend_o)); // R10
endmodule

// File: rtl/link_unit.sv
module link_unit
  import link_seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          take_i,
  input  link_op_e      op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ea_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  output logic [AW-1:0] next_pc_o
);
  localparam logic [AW-1:0] SLOT0 = '0;

  // address that follows the instruction at pc
  function automatic logic [AW-1:0] ret_addr(input logic [AW-1:0] pc);
    return pc + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  // subroutine body starts one word past its return slot
  function automatic logic [AW-1:0] body_addr(input logic [AW-1:0] slot);
    return slot + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    next_pc_o   = pc_i;
    if (step_i) begin
      if (take_i) begin
        mem_we_o    = 1'b1;
        mem_addr_o  = SLOT0;
        mem_wdata_o = pc_i;
        next_pc_o   = body_addr(SLOT0);
      end else begin
        unique case (op_i)
          OP_CALL: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = ea_i;
            mem_wdata_o = ret_addr(pc_i);
            next_pc_o   = body_addr(ea_i);
          end
          OP_JUMP: next_pc_o = ea_i;
          default: next_pc_o = ret_addr(pc_i);
        endcase
      end
    end
  end

  AST_WRITE_BEFORE_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (next_pc_o == AW'(mem_addr_o + 1'b1))); // R2
  AST_WRITE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |-> !mem_we_o); // R10
endmodule

// File: rtl/link_seq.sv
module link_seq
  import link_seq_pkg::*;
#(
  parameter int AW   = 12,
  parameter int NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   ea_i,
  input  logic [NDEV-1:0] req_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [AW-1:0]   mem_wdata_o,
  output logic [AW-1:0]   next_pc_o,
  output logic            int_taken_o,
  output logic            int_on_o,
  output logic [NDEV-1:0] grant_o,
  output logic            grant_valid_o
);
  link_op_e op;
  logic     ion_exec;
  logic     ion_pend;

  assign op = link_op_e'(op_i);

  link_prio #(.NDEV(NDEV)) u_prio (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .grant_o       (grant_o),
    .grant_valid_o (grant_valid_o)
  );

  assign int_taken_o = step_i && int_on_o && grant_valid_o;
  assign ion_exec    = step_i && !int_taken_o && (op == OP_ION);

  link_ie_ctrl u_ie (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .ion_exec_i  (ion_exec),
    .int_taken_i (int_taken_o),
    .int_on_o    (int_on_o),
    .ion_pend_o  (ion_pend)
  );

  link_unit #(.AW(AW)) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .take_i      (int_taken_o),
    .op_i        (op),
    .pc_i        (pc_i),
    .ea_i        (ea_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .next_pc_o   (next_pc_o)
  );

  AST_TAKE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    int_taken_o |-> (int_on_o && grant_valid_o)); // R3
  AST_ENTRY_TO_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    int_taken_o |-> (mem_we_o && mem_addr_o == '0)); // R3
  AST_OFF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_on_o |-> !int_taken_o); // R9
endmodule

// File: tb/link_seq_bench.sv
module link_seq_bench;
  localparam int AW = 12;
  localparam int NDEV = 8;
  localparam int MASK = (1 << AW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            step_i = 1'b0;
  logic [1:0]      op_i = 2'd0;
  logic [AW-1:0]   pc_i = '0;
  logic [AW-1:0]   ea_i = '0;
  logic [NDEV-1:0] req_i = '0;
  logic            mem_we_o;
  logic [AW-1:0]   mem_addr_o;
  logic [AW-1:0]   mem_wdata_o;
  logic [AW-1:0]   next_pc_o;
  logic            int_taken_o;
  logic            int_on_o;
  logic [NDEV-1:0] grant_o;
  logic            grant_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_seq #(.AW(AW), .NDEV(NDEV)) u_link_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i), .pc_i(pc_i),
    .ea_i(ea_i), .req_i(req_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .next_pc_o(next_pc_o),
    .int_taken_o(int_taken_o), .int_on_o(int_on_o), .grant_o(grant_o),
    .grant_valid_o(grant_valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, settle, leave checks to the caller
  task automatic drive(input bit st, input int op, input int pc, input int ea,
                       input int req);
    @(negedge clk);
    step_i = st;
    op_i   = 2'(op);
    pc_i   = AW'(pc);
    ea_i   = AW'(ea);
    req_i  = NDEV'(req);
    #2;
  endtask

  task automatic finish_step();
    @(posedge clk);
    #1;
    step_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  // enable interrupts through the normal sequence: enable, then one step
  task automatic turn_on();
    drive(1, 2, 50, 0, 0);
    finish_step();
    drive(1, 0, 51, 0, 0);
    finish_step();
  endtask

  task automatic t_reset();
    do_reset();
    drive(0, 1, 123, 456, 0);
    chk("R8 int_on after reset", int'(int_on_o), 0);
    chk("R8 no write after reset", int'(mem_we_o), 0);
    chk("R8 next_pc holds", int'(next_pc_o), 123);
  endtask

  task automatic t_call();
    do_reset();
    drive(1, 1, 100, 300, 0);
    chk("R1 call write strobe", int'(mem_we_o), 1);
    chk("R1 call slot addr", int'(mem_addr_o), 300);
    chk("R1 call return addr", int'(mem_wdata_o), 101);
    chk("R2 call next pc", int'(next_pc_o), 301);
    finish_step();
    drive(1, 1, MASK, MASK, 0);
    chk("R1 call wrap return", int'(mem_wdata_o), 0);
    chk("R2 call wrap body", int'(next_pc_o), 0);
    finish_step();
  endtask

  task automatic t_seq_jump();
    do_reset();
    drive(1, 3, 20, 777, 0);
    chk("R4 jump target", int'(next_pc_o), 777);
    chk("R4 jump no write", int'(mem_we_o), 0);
    finish_step();
    drive(1, 0, 40, 9, 0);
    chk("R4 seq next", int'(next_pc_o), 41);
    chk("R4 seq no write", int'(mem_we_o), 0);
    finish_step();
  endtask

  task automatic t_prio();
    int pats[4] = '{8'hA4, 8'h01, 8'h80, 8'hFF};
    do_reset();
    foreach (pats[k]) begin
      int exp_g = 0;
      for (int b = NDEV - 1; b >= 0; b--)
        if (pats[k][b]) exp_g = 1 << b;
      drive(0, 0, 0, 0, pats[k]);
      chk("R6 grant", int'(grant_o), exp_g);
      chk("R6 grant valid", int'(grant_valid_o), 1);
    end
  endtask

  task automatic t_ignored_off();
    do_reset();
    drive(1, 1, 60, 90, 8'h10);
    chk("R9 no take while off", int'(int_taken_o), 0);
    chk("R9 call still executes", int'(mem_addr_o), 90);
    chk("R9 call next pc", int'(next_pc_o), 91);
    finish_step();
  endtask

  task automatic t_ion_delay();
    do_reset();
    drive(1, 2, 70, 0, 0);
    finish_step();
    #1;
    chk("R5 not on after enable", int'(int_on_o), 0);
    // return jump with a request already present
    drive(1, 3, 71, 500, 8'h06);
    chk("R5 return jump not interrupted", int'(int_taken_o), 0);
    chk("R5 return jump target", int'(next_pc_o), 500);
    finish_step();
    #1;
    chk("R5 on after next step", int'(int_on_o), 1);
    drive(1, 1, 500, 800, 8'h06);
    chk("R3 interrupt taken", int'(int_taken_o), 1);
    chk("R3 write to word 0", int'(mem_addr_o), 0);
    chk("R3 return addr is pc", int'(mem_wdata_o), 500);
    chk("R3 entry at word 1", int'(next_pc_o), 1);
    chk("R6 grant during entry", int'(grant_o), 2);
    finish_step();
    #1;
    chk("R3 off after entry", int'(int_on_o), 0);
  endtask

  task automatic t_none();
    do_reset();
    turn_on();
    drive(1, 0, 90, 0, 0);
    chk("R7 empty grant", int'(grant_o), 0);
    chk("R7 empty valid", int'(grant_valid_o), 0);
    chk("R7 no take", int'(int_taken_o), 0);
    chk("R7 executes seq", int'(next_pc_o), 91);
    finish_step();
    #1;
    chk("R7 stays on", int'(int_on_o), 1);
  endtask

  task automatic t_idle();
    do_reset();
    drive(1, 2, 10, 0, 0);
    finish_step();
    repeat (3) begin
      drive(0, 1, 11, 22, 8'h01);
      chk("R10 no write idle", int'(mem_we_o), 0);
      chk("R10 next pc held", int'(next_pc_o), 11);
      @(posedge clk);
      #1;
      chk("R10 still off idle", int'(int_on_o), 0);
    end
    drive(1, 0, 11, 0, 8'h01);
    chk("R10 step after idle not taken", int'(int_taken_o), 0);
    finish_step();
    #1;
    chk("R10 pending survived idle", int'(int_on_o), 1);
  endtask

  initial begin
    t_reset();
    t_call();
    t_seq_jump();
    t_prio();
    t_ignored_off();
    t_ion_delay();
    t_none();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule